// File: doc/BRIEF.md
# Wake-up Alarm Controller

This block is a small synchronous Mealy controller that models how a sleeper reacts to an alarm. It has three states: sleeping, awake but lying in bed, and out of bed. On each rising clock edge it samples two single-bit inputs. One says that the alarm is sounding. The other says that today is a working day. It produces one request that asks for the alarm to be silenced. It also exposes its present state so that the surrounding logic, and a test bench, can follow its progress.

The request is a Mealy function of the present state and the alarm input. The build-time parameter `REGISTERED_OUT` picks how the request reaches the pin. With the value 0 the request is driven straight from that logic, so it is valid in the same cycle. With the value 1 it is passed through a flip-flop, so it appears one cycle later and is free of combinational glitches. A synchronous active-high reset returns the machine to the sleeping state.

Top module: `wake_alarm_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes sleeping. `state_o` uses the codes 00 = sleeping, 01 = in bed and 10 = up. In the registered variant `turn_off_o` is 0 after that edge.
- R2: In the sleeping state with the alarm inactive, the machine stays asleep and the request is 0.
- R3: With the alarm active in any of the three states, the next state is in bed and the request is 1, whatever the weekday input is.
- R4: In bed, with the alarm inactive on a working day, the next state is up and the request is 0.
- R5: In bed, with the alarm inactive on a non-working day, the next state is sleeping and the request is 0.
- R6: In the up state with the alarm inactive, the machine stays up and the request is 0.
- R7: With `REGISTERED_OUT`=0, `turn_off_o` equals the request for the present state and inputs during the same cycle.
- R8: With `REGISTERED_OUT`=1, `turn_off_o` during cycle t+1 equals the request computed in cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_i | input | 1 | Alarm is sounding |
| weekday_i | input | 1 | Today is a working day |
| turn_off_o | output | 1 | Request to silence the alarm |
| state_o | output | 2 | Present state code |

## Verification
On every cycle, the embedded properties check the state transitions: the alarm always leads to the in-bed state, and each branch taken with the alarm quiet goes where it should. They also check that the output in each variant follows the request with the right latency: zero cycles in the immediate variant, one cycle in the registered variant. The bench's scenarios are needed for everything else. They cover walks through the machine that depend on weekday history, the reset being taken in the middle of a sequence, and both variants driven side by side from the same stimulus, so that the one-cycle skew between them can be seen directly.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_SLEEP = 2'b00,
    ST_BED   = 2'b01,
    ST_UP    = 2'b10,
    ST_BAD   = 2'b11
  } wake_state_t;
endpackage

// File: rtl/wake_next_state.sv
module wake_next_state
  import wake_pkg::*;
(
  input  wake_state_t cur_i,
  input  logic        alarm_i,
  input  logic        weekday_i,
  output wake_state_t nxt_o,
  output logic        req_o
);
  always_comb begin
    nxt_o = ST_SLEEP;
    req_o = 1'b0;
    unique case (cur_i)
      ST_SLEEP: begin
        if (alarm_i) begin
          nxt_o = ST_BED;
          req_o = 1'b1;
        end else begin
          nxt_o = ST_SLEEP;
        end
      end
      ST_BED: begin
        if (alarm_i) begin
          nxt_o = ST_BED;
          req_o = 1'b1;
        end else if (weekday_i) begin
          nxt_o = ST_UP;
        end else begin
          nxt_o = ST_SLEEP;
        end
      end
      ST_UP: begin
        if (alarm_i) begin
          nxt_o = ST_BED;
          req_o = 1'b1;
        end else begin
          nxt_o = ST_UP;
        end
      end
      default: begin
        nxt_o = ST_SLEEP;
        req_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/wake_out_stage.sv
module wake_out_stage #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic out_o
);
  generate
    if (REGISTERED) begin : g_reg
      logic out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= req_i;
      end
      assign out_o = out_q;

      // R8: the pin carries the previous cycle's request
      p_delay_one_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_o == $past(req_i)))
        else $error("p_delay_one_r8");
    end else begin : g_imm
      assign out_o = req_i;
    end
  endgenerate
endmodule

// File: rtl/wake_alarm_fsm.sv
module wake_alarm_fsm
  import wake_pkg::*;
#(
  parameter bit REGISTERED_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alarm_i,
  input  logic               weekday_i,
  output logic               turn_off_o,
  output logic [STATE_W-1:0] state_o
);
  wake_state_t state_q;
  wake_state_t state_d;
  logic        req;

  wake_next_state u_next (
    .cur_i     (state_q),
    .alarm_i   (alarm_i),
    .weekday_i (weekday_i),
    .nxt_o     (state_d),
    .req_o     (req)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_SLEEP;
    else     state_q <= state_d;
  end

  wake_out_stage #(.REGISTERED(REGISTERED_OUT)) u_out (
    .clk   (clk),
    .rst   (rst),
    .req_i (req),
    .out_o (turn_off_o)
  );

  assign state_o = state_q;

  p_alarm_to_bed_r3: assert property (@(posedge clk) disable iff (rst)
    (alarm_i && state_q != ST_BAD) |=> (state_o == ST_BED))
    else $error("p_alarm_to_bed_r3");

  p_sleep_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !alarm_i) |=> (state_o == ST_SLEEP))
    else $error("p_sleep_hold_r2");

  p_bed_weekday_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BED && !alarm_i && weekday_i) |=> (state_o == ST_UP))
    else $error("p_bed_weekday_r4");

  p_bed_weekend_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BED && !alarm_i && !weekday_i) |=> (state_o == ST_SLEEP))
    else $error("p_bed_weekend_r5");

  p_up_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UP && !alarm_i) |=> (state_o == ST_UP))
    else $error("p_up_hold_r6");

  generate
    if (!REGISTERED_OUT) begin : g_imm_chk
      // R7: immediate variant follows the alarm in legal states
      p_immediate_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_BAD) |-> (turn_off_o == alarm_i))
        else $error("p_immediate_r7");
    end
  endgenerate
endmodule

// File: tb/tb_wake_alarm_fsm.sv
module tb_wake_alarm_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alarm = 1'b0;
  logic weekday = 1'b0;
  logic out_reg, out_imm;
  logic [1:0] st_reg, st_imm;
  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] m_state = 2'b00;

  always #5 clk = ~clk;

  wake_alarm_fsm #(.REGISTERED_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .alarm_i(alarm), .weekday_i(weekday),
    .turn_off_o(out_reg), .state_o(st_reg));

  wake_alarm_fsm #(.REGISTERED_OUT(1'b0)) dut_imm (
    .clk(clk), .rst(rst), .alarm_i(alarm), .weekday_i(weekday),
    .turn_off_o(out_imm), .state_o(st_imm));

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_next(input logic [1:0] s, input logic a, input logic w);
    if (a) return 2'b01;
    case (s)
      2'b00: return 2'b00;
      2'b01: return w ? 2'b10 : 2'b00;
      2'b10: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic step(input logic a, input logic w, input string tag);
    logic exp_req;
    @(negedge clk);
    alarm = a; weekday = w;
    #1;
    exp_req = a;
    check({tag, " R7 imm out"}, {1'b0, out_imm}, {1'b0, exp_req});
    @(posedge clk); #1;
    m_state = model_next(m_state, a, w);
    check({tag, " state reg"}, st_reg, m_state);
    check({tag, " state imm"}, st_imm, m_state);
    check({tag, " R8 reg out"}, {1'b0, out_reg}, {1'b0, exp_req});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; alarm = 1'b0; weekday = 1'b0;
    @(posedge clk); #1;
    m_state = 2'b00;
    check("R1 reset state", st_reg, 2'b00);
    check("R1 reset state imm", st_imm, 2'b00);
    check("R1 reset reg out", {1'b0, out_reg}, 2'b00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_sleep_hold();
    step(1'b0, 1'b0, "R2 quiet");
    step(1'b0, 1'b1, "R2 quiet weekday");
  endtask

  task automatic t_weekday_morning();
    step(1'b1, 1'b0, "R3 alarm from sleep wkday=0");
    step(1'b1, 1'b1, "R3 alarm while in bed");
    step(1'b0, 1'b1, "R4 get up");
    step(1'b0, 1'b0, "R6 stay up");
    step(1'b1, 1'b0, "R3 alarm while up");
    step(1'b0, 1'b1, "R4 get up again");
  endtask

  task automatic t_weekend_morning();
    step(1'b1, 1'b1, "R3 alarm from sleep wkday=1");
    step(1'b0, 1'b0, "R5 back to sleep");
    step(1'b0, 1'b0, "R2 stay asleep");
  endtask

  task automatic t_reg_skew();
    step(1'b1, 1'b0, "R8 pulse");
    step(1'b0, 1'b0, "R8 after pulse");
    step(1'b1, 1'b0, "R7 pulse");
    step(1'b1, 1'b1, "R7 hold");
    step(1'b0, 1'b1, "R4 leave");
  endtask

  task automatic t_mid_reset();
    step(1'b1, 1'b1, "R3 pre reset");
    do_reset();
    step(1'b0, 1'b1, "R2 after reset");
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_sleep_hold();
    t_weekday_morning();
    do_reset();
    t_weekend_morning();
    t_reg_skew();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule